// File: doc/BRIEF.md
# Sparse Tag Decode and Scatter Unit

This block is the consumer of a 4:1 structured-sparse operand. The moving operand arrives compressed: a value table holds the kept elements, and a tag table holds 16-bit words. Each tag word packs four 4-bit dense indices, one per lane. For every compressed element position, and for each of the four members of its group, the unit does five things in order. It fetches a tag word, picks the nibble for the element's lane, splits that nibble into a row and a column using a runtime column count, reads the stationary weight at that position, and multiply-accumulates the compressed value into the partial sum of that group member.

A run starts with a one-cycle `start` pulse. The elements-per-partition count `epp`, the column count and the active-row count must be stable while the run is in progress. The run covers element positions 0 to 4*epp-1. All arithmetic is unsigned integer. The tag, value and weight tables sit outside the block behind read ports with a latency of one cycle. A run with an unsupported active-row count does no accumulation. It raises the error flag instead and ends at once.

Top module: `sparse_tag_scatter`

## Requirements
- R1: The dense index used for lane L is bits [4L+3:4L] of the fetched tag word, i.e. (tag >> (4*L)) & 0xF.
- R2: The lane of element position p is p & 3.
- R3: For group member j (0..3) of element position p, the tag word is read at address (p >> 2) + j*epp, and the compressed value is read at address p.
- R4: A dense index i is split into row = i / num_cols and column = i % num_cols, where num_cols is in 1..16. The weight is read at address row*16 + column: the row sits in address bits [7:4] and the column in bits [3:0].
- R5: After a valid run, psum member j (bits [32j+31:32j] of `psum_o`) equals the sum, over all positions p, of value[p] * weight[decoded position for p and j]. All partial sums are cleared when `start` is accepted.
- R6: If the active-row count is not a multiple of 4, `err_o` is 1 from the cycle after `start`.
- R7: If the active-row count is not exactly 128, `err_o` is set and no accumulation happens: every partial sum reads 0 and stays 0 until the next `start`. A valid run clears `err_o`.
- R8: `done_o` is a single-cycle pulse. For a valid run it comes 9*16*epp clock edges after the edge that accepts `start`, which is 9 cycles per tag fetch. For an error run it comes in the cycle right after the accepting edge.
- R9: After reset, `psum_o` is 0, `err_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (pulse, accepted when idle) |
| epp_i | input | 8 | Elements per partition (at least 1) |
| num_cols_i | input | 5 | Column count used to split an index (1..16) |
| active_rows_i | input | 8 | Active-row count; only 128 is supported |
| tag_addr_o | output | 10 | Tag table read address |
| tag_rdata_i | input | 16 | Tag word, one cycle after address |
| val_addr_o | output | 10 | Compressed value read address |
| val_rdata_i | input | 8 | Compressed value, one cycle after address |
| wgt_addr_o | output | 8 | Weight read address {row, column} |
| wgt_rdata_i | input | 8 | Weight, one cycle after address |
| psum_o | output | 128 | Four 32-bit partial sums, member j in bits [32j+31:32j] |
| err_o | output | 1 | Unsupported active-row count on last run |
| done_o | output | 1 | Run finished (one-cycle pulse) |

## Verification
The assertions assume a few things about the inputs. `num_cols_i` lies in 1..16, `epp_i` is nonzero, both are held steady for the whole run, and the read ports return data exactly one cycle after the address. The bench models the three tables as registered memories with that latency. It sweeps every column count from 1 to 16 and only issues a new `start` after `done_o`. It also uses several values of `epp`, and runs active-row counts of 126, 124 and 0 so that the error rules are exercised.

// File: rtl/sts_pkg.sv
package sts_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_CAPT,
      ST_DIV,
      ST_WRD,
      ST_MAC
   } sts_state_e;
endpackage

// File: rtl/tag_nibble_sel.sv
module tag_nibble_sel #(
   parameter int TAG_W = 16,
   parameter int LANES = 4,
   localparam int IDX_W = TAG_W / LANES,
   localparam int LG_L  = $clog2(LANES)
) (
   input  logic [TAG_W-1:0] tag_i,
   input  logic [LG_L-1:0]  lane_i,
   output logic [IDX_W-1:0] idx_o
);
   if (TAG_W % LANES != 0) begin : g_bad_split
      $error("tag width must split evenly into lanes");
   end

   always_comb idx_o = tag_i[lane_i*IDX_W +: IDX_W];
endmodule

// File: rtl/idx_divider.sv
module idx_divider #(
   parameter int IDX_W = 4,
   localparam int CNT_W = $clog2(IDX_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [IDX_W-1:0] dividend_i,
   input  logic [IDX_W:0]   divisor_i,
   output logic [IDX_W-1:0] quo_o,
   output logic [IDX_W-1:0] rem_o,
   output logic             busy_o
);
   logic [IDX_W:0]   rem_r;
   logic [IDX_W-1:0] q_r;
   logic [IDX_W-1:0] dvd_r;
   logic [CNT_W-1:0] cnt_r;
   logic [IDX_W:0]   trial;

   always_comb trial = {rem_r[IDX_W-1:0], q_r[IDX_W-1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_r <= '0;
         q_r   <= '0;
         dvd_r <= '0;
         cnt_r <= '0;
      end else if (start_i) begin
         rem_r <= '0;
         q_r   <= dividend_i;
         dvd_r <= dividend_i;
         cnt_r <= CNT_W'(IDX_W);
      end else if (cnt_r != '0) begin
         cnt_r <= cnt_r - 1'b1;
         if (trial >= divisor_i) begin
            rem_r <= trial - divisor_i;
            q_r   <= {q_r[IDX_W-2:0], 1'b1};
         end else begin
            rem_r <= trial;
            q_r   <= {q_r[IDX_W-2:0], 1'b0};
         end
      end
   end

   assign quo_o  = q_r;
   assign rem_o  = rem_r[IDX_W-1:0];
   assign busy_o = (cnt_r != '0);

   // R4
   rem_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> ({1'b0, rem_o} < divisor_i));

   // R4
   quotient_exact_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> ((quo_o * divisor_i + rem_o) == {1'b0, dvd_r}));
endmodule

// File: rtl/mac_bank.sv
module mac_bank #(
   parameter int LANES = 4,
   parameter int VAL_W = 8,
   parameter int WGT_W = 8,
   parameter int ACC_W = 32,
   localparam int LG_L = $clog2(LANES)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   clr_i,
   input  logic                   en_i,
   input  logic [LG_L-1:0]        sel_i,
   input  logic [VAL_W-1:0]       val_i,
   input  logic [WGT_W-1:0]       wgt_i,
   output logic [LANES*ACC_W-1:0] psum_o
);
   if (ACC_W < VAL_W + WGT_W) begin : g_bad_acc
      $error("accumulator narrower than one product");
   end

   logic [ACC_W-1:0] prod;
   always_comb prod = ACC_W'(val_i) * ACC_W'(wgt_i);

   for (genvar g = 0; g < LANES; g++) begin : g_acc
      logic [ACC_W-1:0] acc_r;
      always_ff @(posedge clk) begin
         if (rst || clr_i)
            acc_r <= '0;
         else if (en_i && sel_i == LG_L'(g))
            acc_r <= acc_r + prod;
      end
      assign psum_o[g*ACC_W +: ACC_W] = acc_r;
   end
endmodule

// File: rtl/sparse_tag_scatter.sv
module sparse_tag_scatter
   import sts_pkg::*;
#(
   parameter int TAG_W    = 16,
   parameter int LANES    = 4,
   parameter int EPP_W    = 8,
   parameter int VAL_W    = 8,
   parameter int WGT_W    = 8,
   parameter int ACC_W    = 32,
   parameter int ROWS_W   = 8,
   parameter int ROWS_REQ = 128,
   localparam int IDX_W   = TAG_W / LANES,
   localparam int LG_L    = $clog2(LANES),
   localparam int POS_W   = EPP_W + LG_L,
   localparam int ADDR_W  = EPP_W + LG_L,
   localparam int COLS_W  = IDX_W + 1,
   localparam int WADDR_W = 2 * IDX_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [EPP_W-1:0]       epp_i,
   input  logic [COLS_W-1:0]      num_cols_i,
   input  logic [ROWS_W-1:0]      active_rows_i,
   output logic [ADDR_W-1:0]      tag_addr_o,
   input  logic [TAG_W-1:0]       tag_rdata_i,
   output logic [POS_W-1:0]       val_addr_o,
   input  logic [VAL_W-1:0]       val_rdata_i,
   output logic [WADDR_W-1:0]     wgt_addr_o,
   input  logic [WGT_W-1:0]       wgt_rdata_i,
   output logic [LANES*ACC_W-1:0] psum_o,
   output logic                   err_o,
   output logic                   done_o
);
   if ((1 << LG_L) != LANES) begin : g_bad_lanes
      $error("lane count must be a power of two");
   end
   if (ROWS_REQ % LANES != 0 || ROWS_REQ >= (1 << ROWS_W)) begin : g_bad_rows
      $error("required row count unsupported");
   end

   sts_state_e       st_r;
   logic [POS_W-1:0] pos_r;
   logic [LG_L-1:0]  mem_r;
   logic [VAL_W-1:0] val_r;
   logic [POS_W-1:0] last_pos;
   logic             rows_bad;
   logic             div_start;
   logic             div_busy;
   logic             mac_en;
   logic             clr;
   logic [IDX_W-1:0] nib;
   logic [IDX_W-1:0] quo;
   logic [IDX_W-1:0] rem;

   always_comb begin
      last_pos  = {epp_i, {LG_L{1'b0}}} - 1'b1;
      rows_bad  = (active_rows_i[LG_L-1:0] != '0) || (active_rows_i != ROWS_W'(ROWS_REQ));
      div_start = (st_r == ST_CAPT);
      mac_en    = (st_r == ST_MAC);
      clr       = (st_r == ST_IDLE) && start;
      tag_addr_o = ADDR_W'(pos_r >> LG_L) + ADDR_W'(mem_r) * ADDR_W'(epp_i);
      val_addr_o = pos_r;
      wgt_addr_o = {quo, rem};
   end

   tag_nibble_sel #(.TAG_W(TAG_W), .LANES(LANES)) u_nib (
      .tag_i (tag_rdata_i),
      .lane_i(pos_r[LG_L-1:0]),
      .idx_o (nib)
   );

   idx_divider #(.IDX_W(IDX_W)) u_div (
      .clk       (clk),
      .rst       (rst),
      .start_i   (div_start),
      .dividend_i(nib),
      .divisor_i (num_cols_i),
      .quo_o     (quo),
      .rem_o     (rem),
      .busy_o    (div_busy)
   );

   mac_bank #(.LANES(LANES), .VAL_W(VAL_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_mac (
      .clk   (clk),
      .rst   (rst),
      .clr_i (clr),
      .en_i  (mac_en),
      .sel_i (mem_r),
      .val_i (val_r),
      .wgt_i (wgt_rdata_i),
      .psum_o(psum_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_r   <= ST_IDLE;
         pos_r  <= '0;
         mem_r  <= '0;
         val_r  <= '0;
         err_o  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_r)
            ST_IDLE: if (start) begin
               pos_r <= '0;
               mem_r <= '0;
               err_o <= rows_bad;
               if (rows_bad) done_o <= 1'b1;
               else          st_r   <= ST_ISSUE;
            end
            ST_ISSUE: st_r <= ST_CAPT;
            ST_CAPT: begin
               val_r <= val_rdata_i;
               st_r  <= ST_DIV;
            end
            ST_DIV: if (!div_busy) st_r <= ST_WRD;
            ST_WRD: st_r <= ST_MAC;
            ST_MAC: begin
               st_r  <= ST_ISSUE;
               mem_r <= mem_r + 1'b1;
               if (mem_r == LG_L'(LANES - 1)) begin
                  if (pos_r == last_pos) begin
                     st_r   <= ST_IDLE;
                     done_o <= 1'b1;
                  end else begin
                     pos_r <= pos_r + 1'b1;
                  end
               end
            end
            default: st_r <= ST_IDLE;
         endcase
      end
   end

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R6
   rows_misaligned_chk: assert property (@(posedge clk) disable iff (rst)
      (st_r == ST_IDLE && start && active_rows_i[LG_L-1:0] != '0) |=> err_o);

   // R7
   err_holds_sums_chk: assert property (@(posedge clk) disable iff (rst)
      (err_o && !start) |=> $stable(psum_o));

   // R4
   cols_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      (st_r == ST_DIV) |-> (num_cols_i != '0 && num_cols_i <= COLS_W'(1 << IDX_W)));
endmodule

// File: tb/sparse_tag_scatter_tb.sv
module sparse_tag_scatter_tb;
   localparam int CLK_PERIOD = 10;

   logic         clk = 0;
   logic         rst = 1;
   logic         start = 0;
   logic [7:0]   epp = 1;
   logic [4:0]   ncols = 1;
   logic [7:0]   rows = 128;
   logic [9:0]   tag_addr;
   logic [15:0]  tag_rdata;
   logic [9:0]   val_addr;
   logic [7:0]   val_rdata;
   logic [7:0]   wgt_addr;
   logic [7:0]   wgt_rdata;
   logic [127:0] psum;
   logic         err;
   logic         done;

   logic [15:0] tag_mem [1024];
   logic [7:0]  val_mem [1024];
   logic [7:0]  wgt_mem [256];

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      tag_rdata <= tag_mem[tag_addr];
      val_rdata <= val_mem[val_addr];
      wgt_rdata <= wgt_mem[wgt_addr];
   end

   sparse_tag_scatter u_dut (
      .clk(clk), .rst(rst), .start(start), .epp_i(epp), .num_cols_i(ncols),
      .active_rows_i(rows), .tag_addr_o(tag_addr), .tag_rdata_i(tag_rdata),
      .val_addr_o(val_addr), .val_rdata_i(val_rdata), .wgt_addr_o(wgt_addr),
      .wgt_rdata_i(wgt_rdata), .psum_o(psum), .err_o(err), .done_o(done)
   );

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input int e, input int nc, input int r, input string req);
      longint exp [4];
      int cyc;
      bit good;
      good = (r == 128);
      for (int j = 0; j < 4; j++) exp[j] = 0;
      if (good) begin
         for (int p = 0; p < 4*e; p++) begin
            for (int j = 0; j < 4; j++) begin
               int tw, idx, rw, cl;
               tw  = tag_mem[(p >> 2) + j*e];
               idx = (tw >> (4*(p & 3))) & 15;
               rw  = idx / nc;
               cl  = idx % nc;
               exp[j] += longint'(val_mem[p]) * longint'(wgt_mem[rw*16 + cl]);
            end
         end
      end
      @(negedge clk);
      epp = 8'(e); ncols = 5'(nc); rows = 8'(r); start = 1;
      @(posedge clk);
      @(negedge clk);
      start = 0;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
      check({req, " R8 done timing"}, cyc, good ? 9*16*e : 0);
      check({req, " R6 R7 err"}, err, good ? 0 : 1);
      for (int j = 0; j < 4; j++)
         check({req, " R1 R2 R3 R4 R5 psum"}, psum[j*32 +: 32], exp[j]);
      @(negedge clk);
      check({req, " R8 done single"}, done, 0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         tag_mem[i] = 16'($urandom);
         val_mem[i] = 8'($urandom);
      end
      for (int i = 0; i < 256; i++) wgt_mem[i] = 8'($urandom);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R9
      check("R9 psum", psum, 0);
      check("R9 err", err, 0);
      check("R9 done", done, 0);
      // R4 sweep over every column count
      for (int nc = 1; nc <= 16; nc++) run(2, nc, 128, "R4 sweep");
      run(1, 5, 128, "R3 epp1");
      run(5, 3, 128, "R3 epp5");
      // lane-distinct tags: nibble L = L so lane selection is visible
      for (int i = 0; i < 16; i++) tag_mem[i] = 16'h3210;
      run(4, 16, 128, "R1 R2 lanes");
      run(4, 7, 126, "R6 misaligned");
      run(4, 7, 124, "R7 aligned not 128");
      run(3, 9, 0, "R7 zero rows");
      run(3, 9, 128, "R7 recovery");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule